// File: doc/BRIEF.md
# Horizontal Sync Selector and Line-Period Masker

This block sits between the digitized sync comparators of a video digitizer front end and its line-locked clock generator. It chooses where horizontal sync comes from: a dedicated HSYNC pin in separate-sync mode, or in composite mode either the sync-on-green slicer or the same HSYNC pin carrying composite sync. All sync inputs are assumed to be already sampled in the reference clock domain.

Once the selected sync shows a steady line period, the block predicts where the next leading edge should land and only accepts edges inside a narrow window around that prediction. Accepted edges are reissued as clean pulses of fixed width, so copy-protection pulses and glitches between lines never reach the clock generator or, optionally, the HSYNC output pin. When predicted edges stop arriving for a configurable number of lines, the block raises a coast flag and relearns the period from scratch.

The period tracker is a five-state machine. `ST_HUNT` waits for a first leading edge (HUNT to MEASURE on an edge). `ST_MEASURE` counts to the next edge and stores it as a candidate period (MEASURE to CONFIRM on an edge, MEASURE to HUNT when the counter saturates). `ST_CONFIRM` compares the next interval with the candidate (CONFIRM to LOCKED when they agree, stay with a fresh candidate when they disagree, CONFIRM to HUNT on saturation). `ST_LOCKED` masks and counts missed windows (LOCKED to COAST when the miss limit is reached). `ST_COAST` is a single cycle that clears the tracker (COAST to HUNT unconditionally).

Top module: `hsync_clean_top`

## Requirements
- R1: With `cfg_composite`=0 the selected sync is `hsync_in`, whatever `cfg_src_pin` holds; with masking off, `pll_hsync` and `hsync_out` equal the selected sync delayed by one clock.
- R2: With `cfg_composite`=1 the selected sync is `sog_in` when `cfg_src_pin`=0 and `hsync_in` when `cfg_src_pin`=1.
- R3: A leading edge is a 0-to-1 change of the selected sync. The tracker locks on the third of three leading edges whose second interval differs from the first by no more than the first interval shifted right by `TOL_SHIFT` (default 4); a disagreeing interval becomes the new candidate.
- R4: While locked, with `cfg_pll_mask_off`=0, only leading edges whose distance from the previous accepted (or predicted) edge lies within period ± (period >> `TOL_SHIFT`), bounds included, are accepted; each accepted edge makes `pll_hsync` high for exactly `PULSE_W` (default 4) clocks starting one clock after the edge, and all other selected-sync activity is blanked.
- R5: `cfg_pll_mask_off`=1 makes both `pll_hsync` and `hsync_out` follow the selected sync one clock later, regardless of `cfg_out_mask_off`.
- R6: With `cfg_pll_mask_off`=0 and `cfg_out_mask_off`=1, `hsync_out` follows the selected sync one clock later while `pll_hsync` stays masked; with both bits 0, `hsync_out` equals `pll_hsync`.
- R7: While locked, a window that closes without an accepted edge counts one miss and moves the prediction one period on; when the count reaches `cfg_coast_lines` (0 treated as 1), `coast` goes high, the tracker relearns the period from the start, and `coast` returns low on the clock where lock is regained.
- R8: After reset, `pll_hsync`, `hsync_out` and `coast` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sog_in | input | 1 | Sampled sync-on-green slicer output |
| hsync_in | input | 1 | Sampled HSYNC pin comparator output |
| cfg_composite | input | 1 | 0: separate sync, 1: composite sync |
| cfg_src_pin | input | 1 | Composite source: 0 sync-on-green, 1 HSYNC pin |
| cfg_pll_mask_off | input | 1 | 1 disables masking on both outputs |
| cfg_out_mask_off | input | 1 | 1 disables masking on `hsync_out` only |
| cfg_coast_lines | input | MISS_W | Consecutive missed windows before coast |
| pll_hsync | output | 1 | Cleaned sync to the line-locked clock generator |
| hsync_out | output | 1 | HSYNC output pin |
| coast | output | 1 | High from loss of lock until relock |

## Verification
The cycle where an edge lands exactly on the upper window bound is also the cycle where the tracker would otherwise record a miss and push the prediction forward; acceptance must win. The bench provokes this by stretching one line to period + tolerance and shortening the next to period - tolerance while locked, with masking on. A behavioural model running beside the design decides, on every clock, whether that edge yields a regenerated pulse and no miss, and any disagreement on `pll_hsync`, `hsync_out` or `coast` is reported.

// File: rtl/hsync_clean_pkg.sv
package hsync_clean_pkg;

    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_MEASURE = 3'd1,
        ST_CONFIRM = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_COAST   = 3'd4
    } trk_state_e;

endpackage

// File: rtl/hsync_src_mux.sv
module hsync_src_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic sog_in,
    input  logic hsync_in,
    input  logic cfg_composite,
    input  logic cfg_src_pin,
    output logic sync_sel,
    output logic sync_rise
);

    logic sel_prev_q;

    // separate mode always takes the pin; composite picks by source bit
    always_comb begin
        if (cfg_composite && !cfg_src_pin) sync_sel = sog_in;
        else                               sync_sel = hsync_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_prev_q <= 1'b0;
        else        sel_prev_q <= sync_sel;
    end

    assign sync_rise = sync_sel & ~sel_prev_q;

endmodule

// File: rtl/hsync_period_fsm.sv
module hsync_period_fsm
    import hsync_clean_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TOL_SHIFT = 4,
    parameter int MISS_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_rise,
    input  logic [MISS_W-1:0] cfg_miss_lim,
    output logic              locked,
    output logic              accept,
    output logic              coast
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    trk_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cand_q, period_q;
    logic [CNT_W-1:0]  tol, win_lo, win_hi, diff, cand_tol;
    logic [MISS_W-1:0] miss_q;
    logic              coast_q;
    logic              in_win, win_end, agree, lim_hit, cnt_full;

    always_comb begin
        tol      = period_q >> TOL_SHIFT;
        win_lo   = period_q - tol;
        win_hi   = period_q + tol;
        in_win   = (cnt_q >= win_lo) && (cnt_q <= win_hi);
        cand_tol = cand_q >> TOL_SHIFT;
        diff     = (cnt_q >= cand_q) ? (cnt_q - cand_q) : (cand_q - cnt_q);
        agree    = diff <= cand_tol;
        cnt_full = (cnt_q == CNT_MAX);
        accept   = (state_q == ST_LOCKED) && sync_rise && in_win;
        win_end  = (state_q == ST_LOCKED) && (cnt_q == win_hi) && !accept;
        lim_hit  = ({1'b0, miss_q} + 1'b1) >= {1'b0, cfg_miss_lim};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (sync_rise) state_d = ST_MEASURE;
            ST_MEASURE: begin
                if (sync_rise)     state_d = ST_CONFIRM;
                else if (cnt_full) state_d = ST_HUNT;
            end
            ST_CONFIRM: begin
                if (sync_rise && agree)     state_d = ST_LOCKED;
                else if (!sync_rise && cnt_full) state_d = ST_HUNT;
            end
            ST_LOCKED:  if (win_end && lim_hit) state_d = ST_COAST;
            ST_COAST:   state_d = ST_HUNT;
            default:    state_d = ST_HUNT;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cand_q   <= '0;
            period_q <= '0;
            miss_q   <= '0;
            coast_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    cnt_q  <= sync_rise ? CNT_ONE : '0;
                    miss_q <= '0;
                end
                ST_MEASURE: begin
                    miss_q <= '0;
                    if (sync_rise) begin
                        cand_q <= cnt_q;
                        cnt_q  <= CNT_ONE;
                    end else if (!cnt_full) begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_CONFIRM: begin
                    miss_q <= '0;
                    if (sync_rise) begin
                        if (agree) begin
                            period_q <= cnt_q;
                            coast_q  <= 1'b0;
                        end else begin
                            cand_q <= cnt_q;
                        end
                        cnt_q <= CNT_ONE;
                    end else if (!cnt_full) begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_LOCKED: begin
                    if (accept) begin
                        cnt_q  <= CNT_ONE;
                        miss_q <= '0;
                    end else if (win_end) begin
                        cnt_q  <= tol + CNT_ONE;
                        miss_q <= miss_q + 1'b1;
                        if (lim_hit) coast_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_COAST: begin
                    cnt_q  <= '0;
                    miss_q <= '0;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign locked = (state_q == ST_LOCKED);
    assign coast  = coast_q;

    AST_COAST_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coast_q) |-> $past(state_q == ST_LOCKED)); // R7
    AST_NO_COAST_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |-> !coast_q); // R7
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOCKED) && $past(state_q == ST_LOCKED)) |-> $stable(period_q)); // R3

endmodule

// File: rtl/hsync_pulse_gen.sv
module hsync_pulse_gen #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic pulse
);

    localparam int PW_W = $clog2(PULSE_W + 1);
    localparam logic [PW_W-1:0] LEFT_INIT = PW_W'(PULSE_W - 1);

    logic [PW_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (accept)         left_q <= LEFT_INIT;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign pulse = accept | (left_q != '0);

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LEFT_INIT); // R4

endmodule

// File: rtl/hsync_clean_top.sv
module hsync_clean_top #(
    parameter int CNT_W     = 16,
    parameter int TOL_SHIFT = 4,
    parameter int MISS_W    = 4,
    parameter int PULSE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sog_in,
    input  logic              hsync_in,
    input  logic              cfg_composite,
    input  logic              cfg_src_pin,
    input  logic              cfg_pll_mask_off,
    input  logic              cfg_out_mask_off,
    input  logic [MISS_W-1:0] cfg_coast_lines,
    output logic              pll_hsync,
    output logic              hsync_out,
    output logic              coast
);

    logic sync_sel, sync_rise, locked, accept, regen;
    logic pll_masked, out_masked;
    logic pll_q, out_q;

    hsync_src_mux u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .sog_in        (sog_in),
        .hsync_in      (hsync_in),
        .cfg_composite (cfg_composite),
        .cfg_src_pin   (cfg_src_pin),
        .sync_sel      (sync_sel),
        .sync_rise     (sync_rise)
    );

    hsync_period_fsm #(
        .CNT_W     (CNT_W),
        .TOL_SHIFT (TOL_SHIFT),
        .MISS_W    (MISS_W)
    ) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_rise    (sync_rise),
        .cfg_miss_lim (cfg_coast_lines),
        .locked       (locked),
        .accept       (accept),
        .coast        (coast)
    );

    hsync_pulse_gen #(
        .PULSE_W (PULSE_W)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .pulse  (regen)
    );

    // the PLL-path disable overrides the output-pin disable
    assign pll_masked = locked && !cfg_pll_mask_off;
    assign out_masked = pll_masked && !cfg_out_mask_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            pll_q <= pll_masked ? regen : sync_sel;
            out_q <= out_masked ? regen : sync_sel;
        end
    end

    assign pll_hsync = pll_q;
    assign hsync_out = out_q;

    AST_PLL_RAW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_pll_mask_off) |-> (pll_hsync == $past(sync_sel))); // R5
    AST_OUT_RAW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_pll_mask_off || cfg_out_mask_off) |-> (hsync_out == $past(sync_sel))); // R6

endmodule

// File: tb/hsync_clean_top_test.sv
module hsync_clean_top_test;

    localparam int PW  = 4;
    localparam int MAXC = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sog = 1'b0, hs = 1'b0;
    logic comp = 1'b0, src = 1'b0, pmo = 1'b0, omo = 1'b0;
    logic [3:0] lim = 4'd3;
    logic pll_hsync, hsync_out, coast;

    int n_tests = 0, n_fail = 0;
    bit cmp_en = 1'b0, finished = 1'b0;
    string req_tag = "R8";
    int n_pll_rise = 0, n_out_rise = 0;
    bit pll_prev = 1'b0, out_prev = 1'b0;

    // reference model state
    int  m_st = 0, m_cnt = 0, m_cand = 0, m_per = 0, m_miss = 0, m_pc = 0;
    bit  m_coast = 0, m_prev = 0, e_pll = 0, e_out = 0;

    always #2.5 clk = ~clk;

    hsync_clean_top uut (
        .clk (clk), .rst_n (rst_n), .sog_in (sog), .hsync_in (hs),
        .cfg_composite (comp), .cfg_src_pin (src),
        .cfg_pll_mask_off (pmo), .cfg_out_mask_off (omo),
        .cfg_coast_lines (lim),
        .pll_hsync (pll_hsync), .hsync_out (hsync_out), .coast (coast)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // behavioural model, one step per clock
    always @(posedge clk) begin : model
        bit s, r, acc, wend, agree, pulse, lk;
        int tol, lo, hi, d, eff;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cand = 0; m_per = 0; m_miss = 0; m_pc = 0;
            m_coast = 0; m_prev = 0; e_pll = 0; e_out = 0;
        end else begin
            s     = (comp && !src) ? sog : hs;
            r     = s && !m_prev;
            tol   = m_per / 16;
            lo    = m_per - tol;
            hi    = m_per + tol;
            lk    = (m_st == 3);
            acc   = lk && r && m_cnt >= lo && m_cnt <= hi;
            wend  = lk && m_cnt == hi && !acc;
            d     = m_cnt - m_cand;
            if (d < 0) d = -d;
            agree = d <= m_cand / 16;
            pulse = acc || m_pc != 0;
            e_pll = (!pmo && lk) ? pulse : s;
            e_out = (!pmo && !omo && lk) ? pulse : s;
            m_pc  = acc ? PW - 1 : (m_pc != 0 ? m_pc - 1 : 0);
            eff   = (lim == 0) ? 1 : int'(lim);
            case (m_st)
                0: begin
                    m_miss = 0;
                    if (r) begin m_cnt = 1; m_st = 1; end else m_cnt = 0;
                end
                1: begin
                    m_miss = 0;
                    if (r) begin m_cand = m_cnt; m_cnt = 1; m_st = 2; end
                    else if (m_cnt == MAXC) m_st = 0;
                    else m_cnt++;
                end
                2: begin
                    m_miss = 0;
                    if (r) begin
                        if (agree) begin m_per = m_cnt; m_st = 3; m_coast = 0; end
                        else m_cand = m_cnt;
                        m_cnt = 1;
                    end else if (m_cnt == MAXC) m_st = 0;
                    else m_cnt++;
                end
                3: begin
                    if (acc) begin m_cnt = 1; m_miss = 0; end
                    else if (wend) begin
                        m_cnt = tol + 1;
                        if (m_miss + 1 >= eff) begin m_st = 4; m_coast = 1; end
                        m_miss++;
                    end else m_cnt++;
                end
                default: begin m_cnt = 0; m_miss = 0; m_st = 0; end
            endcase
            m_prev = s;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(pll_hsync == e_pll, {req_tag, " pll_hsync"}, pll_hsync, e_pll);
            chk(hsync_out == e_out, {req_tag, " hsync_out"}, hsync_out, e_out);
            chk(coast == m_coast, {req_tag, " coast"}, coast, m_coast);
        end
        if (pll_hsync && !pll_prev) n_pll_rise++;
        if (hsync_out && !out_prev) n_out_rise++;
        pll_prev = pll_hsync;
        out_prev = hsync_out;
    end

    // one line: pin pulse of 6 at start, optional 2-cycle glitch, sog pulse mid-line
    task automatic line(input int per, input int gl);
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            hs  = (i < 6) || (gl > 0 && i >= gl && i < gl + 2);
            sog = (i >= per / 2) && (i < per / 2 + 3);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hs = 1'b0; sog = 1'b0;
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        n_pll_rise = 0; n_out_rise = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(pll_hsync == 1'b0, "R8 pll_hsync", pll_hsync, 0);
        chk(hsync_out == 1'b0, "R8 hsync_out", hsync_out, 0);
        chk(coast == 1'b0, "R8 coast", coast, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1: separate mode ignores the source bit
        req_tag = "R1"; comp = 0; pmo = 1; src = 0;
        clear_counts();
        repeat (4) line(80, 30);
        chk(n_pll_rise == 8, "R1 pin pulses on pll", n_pll_rise, 8);
        src = 1;
        repeat (4) line(64, 0);

        // R2: composite source choice
        req_tag = "R2"; comp = 1; src = 0;
        clear_counts();
        repeat (4) line(80, 30);
        chk(n_pll_rise == 4, "R2 sog pulses on pll", n_pll_rise, 4);
        src = 1;
        clear_counts();
        repeat (4) line(80, 30);
        chk(n_out_rise == 8, "R2 pin pulses on out", n_out_rise, 8);

        // R3/R4: learn the period, then blank glitches
        req_tag = "R3,R4"; comp = 0; src = 0; pmo = 0; omo = 0;
        idle(200);
        repeat (3) line(80, 0);
        clear_counts();
        repeat (6) line(80, 40);
        chk(n_pll_rise == 6, "R4 glitches blanked on pll", n_pll_rise, 6);
        chk(n_out_rise == 6, "R6 out follows pll when both masked", n_out_rise, 6);
        // window bounds: period+tol then period-tol
        req_tag = "R4 bounds";
        clear_counts();
        line(85, 0);
        line(75, 0);
        line(80, 0);
        chk(n_pll_rise == 3, "R4 boundary edges accepted", n_pll_rise, 3);
        chk(coast == 1'b0, "R4 no coast at bounds", coast, 0);

        // R6: output pin unmasked only
        req_tag = "R6"; omo = 1;
        clear_counts();
        repeat (4) line(80, 40);
        chk(n_out_rise == 8, "R6 raw on out", n_out_rise, 8);
        chk(n_pll_rise == 4, "R6 masked on pll", n_pll_rise, 4);

        // R5: PLL-path disable overrides
        req_tag = "R5"; pmo = 1; omo = 0;
        clear_counts();
        repeat (4) line(80, 40);
        chk(n_out_rise == 8, "R5 raw on out", n_out_rise, 8);
        chk(n_pll_rise == 8, "R5 raw on pll", n_pll_rise, 8);

        // R7: coast after missed windows, clear on relock
        req_tag = "R7"; pmo = 0; lim = 4'd3;
        repeat (2) line(80, 0);
        idle(400);
        chk(coast == 1'b1, "R7 coast raised", coast, 1);
        repeat (2) line(80, 0);
        chk(coast == 1'b1, "R7 coast held while relearning", coast, 1);
        repeat (2) line(80, 0);
        chk(coast == 1'b0, "R7 coast cleared on relock", coast, 0);
        clear_counts();
        repeat (3) line(80, 40);
        chk(n_pll_rise == 3, "R7 masking resumes", n_pll_rise, 3);

        idle(20);
        finish_run();
    end

endmodule